// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

A single-port synchronous memory with a shared data path that lets reads and writes follow each other on every clock, with no dead cycles between a read and a write. Every control input is sampled on the rising edge. Read data comes out of a register. Write data follows its address by one more cycle than read data does, so a read issued right after a write has its data slot in the cycle after the write's data slot. The bus direction control is pipelined together with the operations.

The data path is split into separate input, output and output-drive signals. A pad ring or bus model can combine them into a tristate bus. The word is divided into byte lanes, and each lane is an 8-bit byte plus one parity bit. A per-lane write mask selects which lanes a write stores. A clock-enable input freezes the whole pipeline. A read that targets a word whose write is still in flight gets the newer lanes through a byte-wise bypass.

Top module: `pipe_sram_core`

## Requirements
- R1: An access is accepted at a rising edge only when `cke_n`=0, `cs1_n`=0, `cs2`=1, `cs3_n`=0 and `ld_n`=0. At that edge `we_n`=1 makes it a read and `we_n`=0 makes it a write. If any chip select is inactive, the edge starts nothing and no memory word changes.
- R2: A read accepted at edge E puts the word on `dout` with `dout_en`=1 after the next enabled edge. It stays there until the edge after that. A further access may be accepted on that next edge.
- R3: A write accepted at edge E stores `din` as sampled at the second enabled edge after E. Between those two edges `dout_en` is 0, whatever `oe_n` is.
- R4: Lane k of `din`/`dout` is bits [9k+8:9k], and bit 9k+8 is its parity bit. A write stores lane k only when `bw_n[k]`=0. All other lanes keep their contents. Any mask is legal, and `bw_n`=4'b1111 stores nothing.
- R5: An enabled edge that accepts no access gives `dout_en`=0 after the following enabled edge.
- R6: While `cke_n`=1, the edge changes nothing: no write is stored, the pending operations are held, and `dout` keeps its value.
- R7: `oe_n`=1 forces `dout_en` to 0 at once, without waiting for a clock. `dout_en` is only ever 1 in the data cycle of a read.
- R8: After reset, `dout_en`=0 for any `oe_n`, `dout` is all zeros, and no operation is pending.
- R9: A read whose address matches a write that is in its data cycle at the read edge returns the merged word. Lanes the write selects come from `din`, and the other lanes come from the memory.
- R10: `ld_n`=1 at an enabled edge starts no access, even with all chip selects active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock qualifier; high freezes the core |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Active-low load strobe that starts an access |
| we_n | input | 1 | Active-low write select, sampled with the access |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| bw_n | input | LANES | Active-low per-lane write mask |
| oe_n | input | 1 | Active-low output enable, combinational |
| din | input | LANES*LANE_W | Write data, sampled two edges after the write address |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | High when the core drives `dout` onto the shared bus |

## Verification
The bench builds the core with DEPTH=16 and four 9-bit lanes. At that size it can write and read back every word and apply all sixteen lane masks to one address. It also tries all eight chip-select combinations for both reads and writes. The small address space makes read-after-write hits frequent, and the bench checks them with no gap and with a one-cycle gap, and with stalls placed inside a write's data phase and inside a read's data phase.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } sram_op_e;

   localparam int N_STAGES = 2;

endpackage

// File: rtl/pipe_sram_issue.sv
module pipe_sram_issue
   import pipe_sram_pkg::*;
(
   input  logic     cs1_n,
   input  logic     cs2,
   input  logic     cs3_n,
   input  logic     ld_n,
   input  logic     we_n,
   output sram_op_e op
);

   logic selected;

   always_comb begin
      selected = !cs1_n && cs2 && !cs3_n && !ld_n;
      if (!selected)
         op = OP_NONE;
      else if (we_n)
         op = OP_READ;
      else
         op = OP_WRITE;
   end

endmodule

// File: rtl/pipe_sram_pipe.sv
module pipe_sram_pipe
   import pipe_sram_pkg::*;
#(
   parameter int AW    = 10,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  sram_op_e         in_op,
   input  logic [AW-1:0]    in_addr,
   input  logic [LANES-1:0] in_mask,
   output sram_op_e         s1_op,
   output logic [AW-1:0]    s1_addr,
   output sram_op_e         s2_op,
   output logic [AW-1:0]    s2_addr,
   output logic [LANES-1:0] s2_mask
);

   sram_op_e         op_q   [N_STAGES];
   logic [AW-1:0]    addr_q [N_STAGES];
   logic [LANES-1:0] mask_q [N_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_STAGES; i++) begin
            op_q[i]   <= OP_NONE;
            addr_q[i] <= '0;
            mask_q[i] <= '0;
         end
      end else if (adv) begin
         op_q[0]   <= in_op;
         addr_q[0] <= in_addr;
         mask_q[0] <= in_mask;
         for (int i = 1; i < N_STAGES; i++) begin
            op_q[i]   <= op_q[i-1];
            addr_q[i] <= addr_q[i-1];
            mask_q[i] <= mask_q[i-1];
         end
      end
   end

   assign s1_op   = op_q[0];
   assign s1_addr = addr_q[0];
   assign s2_op   = op_q[N_STAGES-1];
   assign s2_addr = addr_q[N_STAGES-1];
   assign s2_mask = mask_q[N_STAGES-1];

endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
   parameter int DEPTH  = 1024,
   parameter int AW     = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [LANES-1:0] wr_mask,
   input  logic [DW-1:0]    wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_data
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_mask[g])
            mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end

      assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
   end

endmodule

// File: rtl/pipe_sram_rdpath.sv
module pipe_sram_rdpath
   import pipe_sram_pkg::*;
#(
   parameter int AW     = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  sram_op_e         s1_op,
   input  logic [AW-1:0]    s1_addr,
   input  sram_op_e         s2_op,
   input  logic [AW-1:0]    s2_addr,
   input  logic [LANES-1:0] s2_mask,
   input  logic [DW-1:0]    din,
   input  logic [DW-1:0]    arr_q,
   output logic [DW-1:0]    dout
);

   logic          hit;
   logic [DW-1:0] merged;

   assign hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_merge
      assign merged[g*LANE_W +: LANE_W] = (hit && s2_mask[g])
                                        ? din[g*LANE_W +: LANE_W]
                                        : arr_q[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout <= '0;
      else if (adv && s1_op == OP_READ)
         dout <= merged;
   end

endmodule

// File: rtl/pipe_sram_core.sv
module pipe_sram_core
   import pipe_sram_pkg::*;
#(
   parameter int  DEPTH  = 1024,
   parameter int  LANES  = 4,
   parameter int  LANE_W = 9,
   localparam int AW     = $clog2(DEPTH),
   localparam int DW     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke_n,
   input  logic             cs1_n,
   input  logic             cs2,
   input  logic             cs3_n,
   input  logic             ld_n,
   input  logic             we_n,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] bw_n,
   input  logic             oe_n,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    dout,
   output logic             dout_en
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pipe_sram_core: DEPTH must be at least 2");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_pow2
      $error("pipe_sram_core: DEPTH must be a power of two");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("pipe_sram_core: lane count and lane width must be positive");
   end

   logic             adv;
   sram_op_e         new_op;
   sram_op_e         s1_op;
   sram_op_e         s2_op;
   logic [AW-1:0]    s1_addr;
   logic [AW-1:0]    s2_addr;
   logic [LANES-1:0] s2_mask;
   logic [DW-1:0]    arr_q;

   assign adv = !cke_n;

   pipe_sram_issue u_issue (
      .cs1_n (cs1_n),
      .cs2   (cs2),
      .cs3_n (cs3_n),
      .ld_n  (ld_n),
      .we_n  (we_n),
      .op    (new_op)
   );

   pipe_sram_pipe #(.AW(AW), .LANES(LANES)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .in_op   (new_op),
      .in_addr (addr),
      .in_mask (~bw_n),
      .s1_op   (s1_op),
      .s1_addr (s1_addr),
      .s2_op   (s2_op),
      .s2_addr (s2_addr),
      .s2_mask (s2_mask)
   );

   pipe_sram_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .wr_en   (adv && s2_op == OP_WRITE),
      .wr_addr (s2_addr),
      .wr_mask (s2_mask),
      .wr_data (din),
      .rd_addr (s1_addr),
      .rd_data (arr_q)
   );

   pipe_sram_rdpath #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_rdpath (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .s1_op   (s1_op),
      .s1_addr (s1_addr),
      .s2_op   (s2_op),
      .s2_addr (s2_addr),
      .s2_mask (s2_mask),
      .din     (din),
      .arr_q   (arr_q),
      .dout    (dout)
   );

   assign dout_en = (s2_op == OP_READ) && !oe_n;

endmodule

// File: rtl/pipe_sram_core_chk.sv
module pipe_sram_core_chk #(
   parameter int DW = 36
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cke_n,
   input logic          cs1_n,
   input logic          cs2,
   input logic          cs3_n,
   input logic          ld_n,
   input logic          we_n,
   input logic          oe_n,
   input logic [DW-1:0] dout,
   input logic          dout_en
);

   logic sel;
   logic c1_rd, c1_wr, c2_rd, c2_wr;

   assign sel = !cs1_n && cs2 && !cs3_n && !ld_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c1_rd <= 1'b0;
         c1_wr <= 1'b0;
         c2_rd <= 1'b0;
         c2_wr <= 1'b0;
      end else if (!cke_n) begin
         c1_rd <= sel && we_n;
         c1_wr <= sel && !we_n;
         c2_rd <= c1_rd;
         c2_wr <= c1_wr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         p_reset_quiet_r8: assert (!dout_en && dout == '0);
   end

   p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> !oe_n);

   p_drive_only_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> c2_rd);

   p_write_phase_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      c2_wr |-> !dout_en);

   p_deselect_pipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !sel) ##1 !cke_n |=> !dout_en);

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> $stable(dout));

endmodule

bind pipe_sram_core pipe_sram_core_chk #(.DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cke_n   (cke_n),
   .cs1_n   (cs1_n),
   .cs2     (cs2),
   .cs3_n   (cs3_n),
   .ld_n    (ld_n),
   .we_n    (we_n),
   .oe_n    (oe_n),
   .dout    (dout),
   .dout_en (dout_en)
);

// File: tb/sim_pipe_sram_core.sv
module sim_pipe_sram_core;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int LANES      = 4;
   localparam int LANE_W     = 9;
   localparam int AW         = 4;
   localparam int DW         = LANES * LANE_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cke_n = 1'b1;
   logic             cs1_n = 1'b1;
   logic             cs2 = 1'b0;
   logic             cs3_n = 1'b1;
   logic             ld_n = 1'b1;
   logic             we_n = 1'b1;
   logic [AW-1:0]    addr = '0;
   logic [LANES-1:0] bw_n = '1;
   logic             oe_n = 1'b0;
   logic [DW-1:0]    din = '0;
   logic [DW-1:0]    dout;
   logic             dout_en;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // requirement-level model of the pipeline and memory
   logic [DW-1:0]    mem_m [DEPTH];
   logic             b1v = 0, b1w = 0, b2v = 0, b2w = 0;
   logic [AW-1:0]    b1a = '0, b2a = '0;
   logic [LANES-1:0] b1m = '1, b2m = '1;
   logic [DW-1:0]    exp_q = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipe_sram_core #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
      .cs3_n(cs3_n), .ld_n(ld_n), .we_n(we_n), .addr(addr), .bw_n(bw_n),
      .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [DW-1:0] pat(input int n);
      logic [31:0] h;
      h = 32'(n) * 32'h9E37_79B1 + 32'h1234_5677;
      return {4'(n + 5), h ^ {h[15:0], h[31:16]}};
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic step(input logic ckn, input logic c1n, input logic c2, input logic c3n,
                       input logic ldn, input logic wen, input logic [AW-1:0] a,
                       input logic [LANES-1:0] bwn, input logic oen, input string tag);
      logic exp_en;
      @(negedge clk);
      cke_n = ckn; cs1_n = c1n; cs2 = c2; cs3_n = c3n; ld_n = ldn;
      we_n = wen; addr = a; bw_n = bwn; oe_n = oen;
      din = pat(cyc);
      cyc++;
      #1;
      exp_en = b2v && !b2w && !oen;
      check({tag, " dout_en"}, {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, exp_en});
      if (exp_en)
         check({tag, " dout"}, dout, exp_q);
      @(posedge clk);
      if (!ckn) begin
         if (b2v && b2w)
            for (int k = 0; k < LANES; k++)
               if (!b2m[k]) mem_m[b2a][k*LANE_W +: LANE_W] = din[k*LANE_W +: LANE_W];
         if (b1v && !b1w)
            exp_q = mem_m[b1a];
         b2v = b1v; b2w = b1w; b2a = b1a; b2m = b1m;
         b1v = !c1n && c2 && !c3n && !ldn;
         b1w = !wen; b1a = a; b1m = bwn;
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [LANES-1:0] bwn, input string tag);
      step(0, 0, 1, 0, 0, 0, a, bwn, 0, tag);
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic oen, input string tag);
      step(0, 0, 1, 0, 0, 1, a, '1, oen, tag);
   endtask

   task automatic idle(input string tag);
      step(0, 1, 1, 0, 0, 1, '0, '1, 0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R8: reset state with output enable active
      #(CLK_PERIOD * 3 + 2);
      check("R8 dout_en", {{(DW-1){1'b0}}, dout_en}, '0);
      check("R8 dout", dout, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R3: fill every word back-to-back, full mask, oe held low
      for (int a = 0; a < DEPTH; a++) wr(AW'(a), 4'b0000, "R3 fill");
      idle("R5 after fill");
      idle("R5 after fill");

      // R2: back-to-back reads of every word
      for (int a = 0; a < DEPTH; a++) rd(AW'(a), 0, "R2 read");
      idle("R5 after reads");
      idle("R5 after reads");

      // R4 R9: every lane mask on one word, read right behind the write
      for (int m = 0; m < 16; m++) begin
         wr(4'd3, 4'(m), "R4 mask write");
         rd(4'd3, 0, "R9 bypass read");
      end
      idle("R5");
      idle("R5");
      rd(4'd3, 0, "R4 readback");
      idle("R5");
      idle("R5");

      // R9: write, gap, read; mixed addresses
      for (int a = 0; a < 6; a++) begin
         wr(AW'(a + 4), 4'(a * 5), "R9 gap write");
         idle("R9 gap");
         rd(AW'(a + 4), 0, "R9 gap read");
         wr(AW'(a + 8), 4'b0110, "R9 write");
         rd(AW'(a + 8), 0, "R9 read hit");
         rd(AW'(a + 4), 0, "R2 read other");
      end
      idle("R5");
      idle("R5");

      // R1: all chip-select combinations for reads and writes
      for (int c = 0; c < 8; c++) begin
         step(0, c[0], c[1], c[2], 0, 0, 4'd12, 4'b0000, 0, "R1 cs write");
         idle("R1 gap");
         idle("R1 gap");
         step(0, c[0], c[1], c[2], 0, 1, 4'd12, '1, 0, "R1 cs read");
         idle("R1 gap");
         rd(4'd12, 0, "R1 readback");
         idle("R1 gap");
         idle("R1 gap");
      end

      // R10: load strobe high starts nothing
      step(0, 0, 1, 0, 1, 1, 4'd5, '1, 0, "R10 no load read");
      step(0, 0, 1, 0, 1, 0, 4'd5, 4'b0000, 0, "R10 no load write");
      idle("R10");
      idle("R10");
      rd(4'd5, 0, "R10 readback");
      idle("R5");
      idle("R5");

      // R5: deselect pipelining right after a read
      rd(4'd7, 0, "R5 read");
      idle("R5 deselect 1");
      idle("R5 deselect 2");

      // R6: stall inside a write data phase and a read data phase
      wr(4'd9, 4'b1010, "R6 write");
      rd(4'd9, 0, "R6 read");
      step(1, 0, 1, 0, 0, 0, 4'd1, 4'b0000, 0, "R6 stall");
      step(1, 1, 0, 1, 1, 0, 4'd2, 4'b0000, 0, "R6 stall");
      idle("R6 resume");
      step(1, 1, 1, 0, 0, 1, '0, '1, 0, "R6 stall on read data");
      step(1, 1, 1, 0, 0, 1, '0, '1, 0, "R6 stall on read data");
      idle("R6 resume");
      idle("R6 resume");
      rd(4'd1, 0, "R6 no stall write");
      rd(4'd2, 0, "R6 no stall write");
      rd(4'd9, 0, "R6 readback");
      idle("R5");
      idle("R5");

      // R7: output enable gating on read data cycles
      for (int a = 0; a < 8; a++) rd(AW'(a), a[0], "R7 oe toggle");
      idle("R7");
      idle("R7");
      rd(4'd6, 0, "R7 read");
      step(0, 0, 1, 0, 0, 1, 4'd6, '1, 1, "R7 oe high");
      @(negedge clk);
      oe_n = 1'b0;
      #1;
      check("R7 oe low mid-cycle", {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, 1'b1});
      oe_n = 1'b1;
      #1;
      check("R7 oe high mid-cycle", {{(DW-1){1'b0}}, dout_en}, '0);
      cke_n = 1'b1;
      @(posedge clk);
      idle("R7 end");
      idle("R7 end");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule